// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Detector

This block turns a set of already-filtered GPIO pin signals into one interrupt request per line. Each line first passes its pin through an optional inverter. A single detector then looks for either a rising transition or a high level on the result, so falling-edge and active-low sensing come from the inverter and not from a second detector. The line's configuration inputs choose edge or level sensing, the inversion, and whether the pin may raise status at all.

Software reaches each line through one control word. The byte address is a base plus eight times the line number. The four low data bits of a write act as strobes: one acknowledges the pending status, one forces it set, one masks the line and one unmasks it. Reading the same address returns the pending status and the enable. A line's interrupt output is high while its status and its enable are both set.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every line reads 0 and every `irq_out` bit is 0. `rst_n` clears the state asynchronously, and its release takes effect through a two-stage synchronizer.
- R2: Line k is addressed at byte address 0x800 + 8*k for k = 0..LINES-1. A write to any other address, whether misaligned, below the base or past the last line, changes no line. A read of an unmapped address returns 0.
- R3: A write with data bit 0 set acknowledges the line, so its status reads 0 afterwards. Read bit 0 holds the status.
- R4: A write with data bit 1 set forces the status to 1. When bits 0 and 1 are both set in one write, the status ends at 1.
- R5: Data bit 3 sets the enable and data bit 2 clears it. When both are set, the enable ends at 0. Read bit 3 holds the enable, and read bits 1 and 2 are 0.
- R6: `irq_out[k]` is status AND enable of line k, and it updates on the same clock edge as those registers.
- R7: In edge mode (`cfg_edge[k]`=1) the status sets on a clock edge where the adjusted input is 1 and was 0 at the previous edge. It then stays set until acknowledged, however long the input stays high or after it falls.
- R8: In level mode (`cfg_edge[k]`=0) the status sets at every clock edge where the adjusted input is 1. An acknowledge while the input is high shows status 0 for one cycle, and the status sets again at the next edge.
- R9: The adjusted input is `pin_in[k]` XOR `cfg_invert[k]`. With inversion on, a falling pin (edge mode) or a low pin (level mode) sets the status, and a rising pin does not.
- R10: While `cfg_int_en[k]` is 0, pin activity never sets the status.
- R11: When an acknowledge and a detection fall on the same edge, the acknowledge wins for that edge. In edge mode that rising edge is not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| pin_in | input | LINES | Filtered pin levels |
| cfg_invert | input | LINES | Per-line input inversion |
| cfg_edge | input | LINES | 1 = edge sensing, 0 = level sensing |
| cfg_int_en | input | LINES | Allows the pin to raise status |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 4 | Strobes: bit0 ack, bit1 force, bit2 mask, bit3 unmask |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 4 | Bit0 status, bit3 enable, others 0 |
| irq_out | output | LINES | Per-line interrupt requests |

## Verification
Edge mode is driven with a single high pulse, with a long high level and with a rising edge that coincides with an acknowledge. These cases separate true edge capture from level capture, and show whether an acknowledge racing a detection is handled correctly. Level mode is acknowledged while the pin is still high, which shows the one-cycle dip and the re-assertion that edge mode must not produce. An inverted line is given a falling edge and then a rising one, to show that only the inverted polarity is sensed. Strobe combinations and misaligned or out-of-range addresses show the priority between set and clear and confirm that the address decode is exact.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned CTL_W    = 4;
  localparam int unsigned ACK_B    = 0;
  localparam int unsigned FORCE_B  = 1;
  localparam int unsigned MASK_B   = 2;
  localparam int unsigned UNMASK_B = 3;
endpackage

// File: rtl/gpio_irq_rst_sync.sv
module gpio_irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic inv_i,
  input  logic edge_i,
  input  logic arm_i,
  output logic ev_o
);
  logic adj;
  logic prev_q;
  logic prev_d;

  assign adj = pin_i ^ inv_i;

  always_comb begin
    prev_d = adj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign ev_o = arm_i & adj & (~edge_i | ~prev_q);

  // R7
  edge_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_o && edge_i) |=> !(ev_o && edge_i));
endmodule

// File: rtl/gpio_irq_line_regs.sv
module gpio_irq_line_regs
  import gpio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_i,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic             stat_o,
  output logic             en_o
);
  logic stat_q, stat_d, stat_upd;
  logic en_q, en_d, en_upd;
  logic do_ack, do_force, do_mask, do_unmask;

  assign do_ack    = wr_i & wdata_i[ACK_B];
  assign do_force  = wr_i & wdata_i[FORCE_B];
  assign do_mask   = wr_i & wdata_i[MASK_B];
  assign do_unmask = wr_i & wdata_i[UNMASK_B];

  always_comb begin
    stat_upd = wr_i | ev_i;
    if (do_ack) stat_d = do_force;
    else        stat_d = stat_q | ev_i | do_force;
  end

  always_comb begin
    en_upd = do_mask | do_unmask;
    en_d   = ~do_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_q <= 1'b0;
    else if (stat_upd) stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (en_upd) en_q <= en_d;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[ACK_B] && !wdata_i[FORCE_B]) |=> !stat_o);
  // R4
  force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[FORCE_B]) |=> stat_o);
  // R5
  mask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[MASK_B]) |=> !en_o);
  // R5
  unmask_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[UNMASK_B] && !wdata_i[MASK_B]) |=> en_o);
  // R10
  status_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o) |-> $past(ev_i || (wr_i && wdata_i[FORCE_B])));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES       = 4,
  parameter int unsigned AW          = 16,
  parameter int unsigned BASE_ADDR   = 32'h0800,
  parameter int unsigned STRIDE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_in,
  input  logic [LINES-1:0] cfg_invert,
  input  logic [LINES-1:0] cfg_edge,
  input  logic [LINES-1:0] cfg_int_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [CTL_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [CTL_W-1:0] rd_data,
  output logic [LINES-1:0] irq_out
);
  localparam int unsigned STRIDE = 1 << STRIDE_LOG2;

  logic             srst_n;
  logic [LINES-1:0] wr_hit;
  logic [LINES-1:0] rd_hit;
  logic [LINES-1:0] ev;
  logic [LINES-1:0] stat;
  logic [LINES-1:0] en;
  logic [CTL_W-1:0] rd_word [LINES];

  gpio_irq_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [AW-1:0] LADDR = AW'(BASE_ADDR + g * STRIDE);

    assign wr_hit[g] = wr_en && (wr_addr == LADDR);
    assign rd_hit[g] = (rd_addr == LADDR);

    gpio_irq_detect u_det (
      .clk    (clk),
      .rst_n  (srst_n),
      .pin_i  (pin_in[g]),
      .inv_i  (cfg_invert[g]),
      .edge_i (cfg_edge[g]),
      .arm_i  (cfg_int_en[g]),
      .ev_o   (ev[g])
    );

    gpio_irq_line_regs u_regs (
      .clk     (clk),
      .rst_n   (srst_n),
      .ev_i    (ev[g]),
      .wr_i    (wr_hit[g]),
      .wdata_i (wr_data),
      .stat_o  (stat[g]),
      .en_o    (en[g])
    );

    assign irq_out[g] = stat[g] & en[g];
    assign rd_word[g] = rd_hit[g] ? {en[g], 2'b00, stat[g]} : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < LINES; k++) rd_data = rd_data | rd_word[k];
  end

  // R2
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(wr_hit));
endmodule

// File: tb/test_gpio_irq_unit.sv
`timescale 1ns/100ps
module test_gpio_irq_unit;
  localparam int N = 4;

  typedef struct {
    logic [15:0] addr;
    logic [3:0]  rd;
    logic [N-1:0] irq;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_in = '0, cfg_invert = '0, cfg_edge = '0, cfg_int_en = '0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic [N-1:0] irq_out;

  int checks = 0, failures = 0;
  bit done = 0;
  item_t q[$];
  logic st [N];
  logic en [N];

  always #2 clk = ~clk;

  gpio_irq_unit i_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg_invert(cfg_invert),
    .cfg_edge(cfg_edge), .cfg_int_en(cfg_int_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [15:0] laddr(int k);
    return 16'h0800 + 16'(k * 8);
  endfunction

  task automatic tick();
    @(posedge clk); #0.5;
  endtask

  task automatic wr(logic [15:0] a, logic [3:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic check_all(string tag);
    logic [N-1:0] iv;
    for (int k = 0; k < N; k++) iv[k] = st[k] & en[k];
    for (int k = 0; k < N; k++) begin
      item_t it;
      it.addr = laddr(k); it.rd = {en[k], 2'b00, st[k]}; it.irq = iv; it.tag = tag;
      q.push_back(it);
    end
  endtask

  task automatic check_unmapped(logic [15:0] a, string tag);
    item_t it;
    logic [N-1:0] iv;
    for (int k = 0; k < N; k++) iv[k] = st[k] & en[k];
    it.addr = a; it.rd = 4'h0; it.irq = iv; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        rd_addr = it.addr;
        #0.2;
        checks++;
        if (rd_data !== it.rd) begin
          failures++;
          $display("FAIL %s addr=%h rd_data actual=%h expected=%h", it.tag, it.addr, rd_data, it.rd);
        end
        checks++;
        if (irq_out !== it.irq) begin
          failures++;
          $display("FAIL %s irq_out actual=%b expected=%b", it.tag, irq_out, it.irq);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin st[k] = 0; en[k] = 0; end
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check_all("R1 reset state");

    wr(laddr(0), 4'h8); en[0] = 1; check_all("R5 unmask");
    wr(laddr(0), 4'h2); st[0] = 1; check_all("R4 force, R6 irq");
    wr(laddr(0), 4'h1); st[0] = 0; check_all("R3 ack");
    wr(laddr(0), 4'h2); st[0] = 1;
    wr(laddr(0), 4'hC); en[0] = 0; check_all("R5 mask beats unmask, R6");
    wr(laddr(0), 4'h3); st[0] = 1; check_all("R4 force beats ack");
    wr(laddr(0), 4'h9); st[0] = 0; en[0] = 1; check_all("R3 ack with unmask");

    wr(16'h0801, 4'h2); wr(16'h07F8, 4'h2); wr(16'h0820, 4'h2);
    check_all("R2 ignored addresses");
    check_unmapped(16'h0801, "R2 unmapped read");

    pin_in[0] = 1'b1; repeat (3) tick();
    check_all("R10 pin masked by cfg_int_en");
    pin_in[0] = 1'b0;

    cfg_edge[1] = 1'b1; cfg_int_en[1] = 1'b1;
    wr(laddr(1), 4'h8); en[1] = 1; check_all("R7 setup");
    pin_in[1] = 1'b1; tick(); st[1] = 1; check_all("R7 rising edge");
    pin_in[1] = 1'b0; tick(); tick(); check_all("R7 status held");
    wr(laddr(1), 4'h1); st[1] = 0; check_all("R7 ack");
    pin_in[1] = 1'b1; tick(); st[1] = 1;
    wr(laddr(1), 4'h1); st[1] = 0; tick(); check_all("R7 no retrigger while high");

    pin_in[1] = 1'b0; tick();
    wr(laddr(1), 4'h2); st[1] = 1;
    pin_in[1] = 1'b1; wr(laddr(1), 4'h1); st[1] = 0; check_all("R11 ack wins over edge");
    tick(); check_all("R11 edge not recorded");
    pin_in[1] = 1'b0;

    cfg_int_en[2] = 1'b1;
    wr(laddr(2), 4'h8); en[2] = 1;
    pin_in[2] = 1'b1; tick(); st[2] = 1; check_all("R8 level set");
    wr(laddr(2), 4'h1); st[2] = 0; check_all("R8 R11 ack dip");
    tick(); st[2] = 1; check_all("R8 level re-asserts");
    pin_in[2] = 1'b0; wr(laddr(2), 4'h1); st[2] = 0; tick(); check_all("R8 cleared when low");

    pin_in[3] = 1'b1; tick();
    cfg_invert[3] = 1'b1; cfg_edge[3] = 1'b1; tick(); tick();
    cfg_int_en[3] = 1'b1; wr(laddr(3), 4'h8); en[3] = 1; tick();
    check_all("R9 high pin inactive when inverted");
    pin_in[3] = 1'b0; tick(); st[3] = 1; check_all("R9 falling edge detected");
    wr(laddr(3), 4'h1); st[3] = 0;
    pin_in[3] = 1'b1; tick(); tick(); check_all("R9 rising edge ignored");

    tick(); tick();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule